// File: doc/BRIEF.md
# Buffer-Gated Priority DMA Queue Arbiter

This block decides which of four on-chip packet queues a DMA engine drains next into host memory. It tracks two saturating counters for each queue: the packets waiting on chip, and the free descriptors the host has posted on that queue's ring. A queue can win only when both counters are non-zero. Among the queues that can win, the highest index wins. Queue 3 outranks queue 2, and queue 0 ranks lowest.

A grant covers exactly one packet. The grant and its index stay frozen until the DMA engine pulses a completion. The completion retires one packet and one descriptor from the granted queue. A queue that has packets but no descriptors is reported as stalled and is skipped, so lower queues keep moving. Software can therefore steer the effective order by how fast it returns descriptors to each ring. Arrivals come in as one pulse per packet. Descriptor returns come in as a count per ring.

Top module: `dqa_queue_arbiter`

## Requirements
- R1: After reset, every packet level and free-descriptor level reads 0, `grant_valid` is 0 and `stall` is 0.
- R2: A grant is issued only to a queue whose packet level and free level are both non-zero in the cycle before the grant rises.
- R3: When several queues qualify, the grant goes to the one with the highest index.
- R4: A higher queue with packets but zero free descriptors is passed over, and a qualifying lower queue is granted instead.
- R5: While `grant_valid` is 1 and `xfer_done` is 0, `grant_valid` stays 1 and `grant_q` stays unchanged.
- R6: A `xfer_done` pulse during a grant lowers that queue's packet level and free level by one each. A `xfer_done` while no grant is active changes nothing.
- R7: Each `pkt_arrive[i]` pulse raises packet level i by one. Slice i of `desc_ret` (bits 8i+7..8i) is added to free level i in the same cycle.
- R8: Both levels saturate at 255 instead of wrapping.
- R9: If an arrival or a return lands in the same cycle as a completion on the same queue, both changes apply.
- R10: `stall[i]` is 1 exactly when packet level i is non-zero and free level i is zero.
- R11: Arbitration runs only while no grant is active. After a completion, `grant_valid` drops for at least one cycle. An idle cycle with a qualifying queue is followed by a grant on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_arrive | input | 4 | One pulse per packet entering queue i |
| desc_ret | input | 32 | Per-ring count of descriptors handed back, 8 bits per ring |
| xfer_done | input | 1 | Completion pulse for the packet under grant |
| grant_valid | output | 1 | A one-packet transfer is granted |
| grant_q | output | 2 | Index of the granted queue |
| stall | output | 4 | Queue i holds packets but its ring has no free descriptor |
| pkt_level | output | 32 | Packet count per queue, 8 bits each |
| free_level | output | 32 | Free-descriptor count per ring, 8 bits each |

## Verification
On every cycle, the assertions check four things:
- The grant stays frozen until completion.
- `grant_valid` drops right after a completion.
- An idle cycle with a qualifying queue turns into a grant.
- Each new grant lands on the highest queue that qualified the cycle before.

They also check that a full free level holds at 255 unless that ring is being retired. Only the bench scenarios can show the following:
- The exact running counts.
- The order of a burst of grants as buffers run out on the top queue.
- Completions that coincide with arrivals or returns.
- A stray completion while idle.

// File: rtl/dqa_pkg.sv
package dqa_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dqa_sat_ctr.sv
module dqa_sat_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] inc,
    input  logic          dec,
    output logic [CW-1:0] count
);
    localparam logic [CW+1:0] MAXV = {2'b00, {CW{1'b1}}};

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW+1:0] sum;

    always_comb begin
        sum = {2'b00, cnt_q} + {2'b00, inc} - {{(CW+1){1'b0}}, dec};
        if (sum[CW+1])
            cnt_d = '0;               // guard: never retire below zero
        else if (sum > MAXV)
            cnt_d = {CW{1'b1}};       // saturate at the top
        else
            cnt_d = sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/dqa_prio_pick.sv
module dqa_prio_pick #(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic [NQ-1:0] cand,
    output logic          found,
    output logic [QW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NQ; i++) begin
            if (cand[i]) begin        // later (higher) index overrides
                found = 1'b1;
                idx   = QW'(i);
            end
        end
    end
endmodule

// File: rtl/dqa_queue_arbiter.sv
module dqa_queue_arbiter
    import dqa_pkg::*;
#(
    parameter int NQ = 4,
    parameter int CW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NQ-1:0]         pkt_arrive,
    input  logic [NQ*CW-1:0]      desc_ret,
    input  logic                  xfer_done,
    output logic                  grant_valid,
    output logic [$clog2(NQ)-1:0] grant_q,
    output logic [NQ-1:0]         stall,
    output logic [NQ*CW-1:0]      pkt_level,
    output logic [NQ*CW-1:0]      free_level
);
    localparam int QW = $clog2(NQ);

    typedef struct packed {
        arb_state_e    st;
        logic [QW-1:0] q;
    } arb_t;

    arb_t          arb_d, arb_q;
    logic          done_ok;
    logic [NQ-1:0] retire;
    logic [NQ-1:0] has_pkt, has_buf, elig;
    logic          pick_found;
    logic [QW-1:0] pick_idx;

    // completion accepted only while a grant is outstanding
    always_comb begin
        done_ok = (arb_q.st == ARB_BUSY) && xfer_done;
        retire  = '0;
        if (done_ok) retire[arb_q.q] = 1'b1;
    end

    for (genvar i = 0; i < NQ; i++) begin : g_queue
        logic [CW-1:0] pcnt, fcnt;

        dqa_sat_ctr #(.CW(CW)) u_pkt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   ({{(CW-1){1'b0}}, pkt_arrive[i]}),
            .dec   (retire[i]),
            .count (pcnt)
        );

        dqa_sat_ctr #(.CW(CW)) u_free (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (desc_ret[i*CW +: CW]),
            .dec   (retire[i]),
            .count (fcnt)
        );

        assign has_pkt[i]             = |pcnt;
        assign has_buf[i]             = |fcnt;
        assign elig[i]                = has_pkt[i] && has_buf[i];
        assign stall[i]               = has_pkt[i] && !has_buf[i];
        assign pkt_level[i*CW +: CW]  = pcnt;
        assign free_level[i*CW +: CW] = fcnt;
    end

    dqa_prio_pick #(.NQ(NQ), .QW(QW)) u_pick (
        .cand  (elig),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        arb_d = arb_q;
        case (arb_q.st)
            ARB_IDLE: begin
                if (pick_found) begin
                    arb_d.st = ARB_BUSY;
                    arb_d.q  = pick_idx;
                end
            end
            ARB_BUSY: begin
                if (done_ok) arb_d.st = ARB_IDLE;
            end
            default: arb_d.st = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q.st <= ARB_IDLE;
            arb_q.q  <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign grant_valid = (arb_q.st == ARB_BUSY);
    assign grant_q     = arb_q.q;
endmodule

// File: rtl/dqa_checker.sv
module dqa_checker #(
    parameter int NQ = 4,
    parameter int CW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  xfer_done,
    input logic                  grant_valid,
    input logic [$clog2(NQ)-1:0] grant_q,
    input logic [NQ*CW-1:0]      pkt_level,
    input logic [NQ*CW-1:0]      free_level
);
    logic [NQ-1:0] el;

    always_comb begin
        for (int i = 0; i < NQ; i++)
            el[i] = (pkt_level[i*CW +: CW] != '0) && (free_level[i*CW +: CW] != '0);
    end

    assert_hold_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !xfer_done |=> grant_valid && $stable(grant_q));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && xfer_done |=> !grant_valid);

    assert_idle_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid && (|el) |=> grant_valid);

    // R2, R3 and R4: the new grant is the top queue that qualified one cycle earlier
    assert_top_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (($past(el) >> grant_q) == NQ'(1)));

    for (genvar i = 0; i < NQ; i++) begin : g_sat
        assert_free_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (free_level[i*CW +: CW] == {CW{1'b1}}) &&
            !(grant_valid && xfer_done && (grant_q == i))
            |=> free_level[i*CW +: CW] == {CW{1'b1}});
    end
endmodule

bind dqa_queue_arbiter dqa_checker #(.NQ(NQ), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_done   (xfer_done),
    .grant_valid (grant_valid),
    .grant_q     (grant_q),
    .pkt_level   (pkt_level),
    .free_level  (free_level)
);

// File: tb/sim_dqa_queue_arbiter.sv
module sim_dqa_queue_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pkt_arrive = '0;
    logic [31:0] desc_ret = '0;
    logic        xfer_done = 1'b0;
    logic        grant_valid;
    logic [1:0]  grant_q;
    logic [3:0]  stall;
    logic [31:0] pkt_level, free_level;

    int nchk = 0;
    int nfail = 0;
    int exp_pkt[4];
    int exp_free[4];
    int exp_q[$];
    logic gv_prev = 1'b0;

    always #4 clk = ~clk;   // 8 ns period

    dqa_queue_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .pkt_arrive(pkt_arrive), .desc_ret(desc_ret),
        .xfer_done(xfer_done), .grant_valid(grant_valid), .grant_q(grant_q),
        .stall(stall), .pkt_level(pkt_level), .free_level(free_level)
    );

    function automatic int sat(int v);
        if (v > 255) return 255;
        if (v < 0) return 0;
        return v;
    endfunction

    task automatic chk(string tag, int act, int expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic chk_levels(string tag);
        for (int q = 0; q < 4; q++) begin
            chk($sformatf("%s R7 pkt level q%0d", tag, q), int'(pkt_level[q*8 +: 8]), exp_pkt[q]);
            chk($sformatf("%s R7 free level q%0d", tag, q), int'(free_level[q*8 +: 8]), exp_free[q]);
            chk($sformatf("%s R10 stall q%0d", tag, q), int'(stall[q]),
                (exp_pkt[q] > 0 && exp_free[q] == 0) ? 1 : 0);
        end
    endtask

    // scoreboard monitor: each new grant pops one expected queue index
    always @(negedge clk) begin
        if (rst_n && grant_valid && !gv_prev) begin
            if (exp_q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R2 unexpected grant actual=%0d expected=none", grant_q);
            end else begin
                chk("R3 grant order", int'(grant_q), exp_q.pop_front());
            end
        end
        gv_prev = grant_valid;
    end

    task automatic drive(input logic [3:0] arr, input logic [31:0] rets);
        @(negedge clk);
        pkt_arrive = arr;
        desc_ret   = rets;
        @(negedge clk);
        pkt_arrive = '0;
        desc_ret   = '0;
        for (int q = 0; q < 4; q++) begin
            exp_pkt[q]  = sat(exp_pkt[q] + int'(arr[q]));
            exp_free[q] = sat(exp_free[q] + int'(rets[q*8 +: 8]));
        end
    endtask

    task automatic serve(input int want, input logic [3:0] arr, input logic [31:0] rets);
        int w;
        int g;
        exp_q.push_back(want);
        w = 0;
        while (!grant_valid && w < 50) begin
            @(negedge clk);
            w++;
        end
        if (!grant_valid) begin
            chk("R2 expected grant appears", 0, 1);
            void'(exp_q.pop_back());
            return;
        end
        g = int'(grant_q);
        repeat (2) begin
            @(negedge clk);
            chk("R5 grant held", int'(grant_valid), 1);
            chk("R5 index held", int'(grant_q), g);
        end
        xfer_done  = 1'b1;
        pkt_arrive = arr;
        desc_ret   = rets;
        @(negedge clk);
        xfer_done  = 1'b0;
        pkt_arrive = '0;
        desc_ret   = '0;
        for (int q = 0; q < 4; q++) begin
            exp_pkt[q]  = sat(exp_pkt[q] + int'(arr[q]) - ((q == g) ? 1 : 0));
            exp_free[q] = sat(exp_free[q] + int'(rets[q*8 +: 8]) - ((q == g) ? 1 : 0));
        end
        chk("R11 grant drops after done", int'(grant_valid), 0);
        chk_levels("R6 R9 after done");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int q = 0; q < 4; q++) begin exp_pkt[q] = 0; exp_free[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no grant after reset", int'(grant_valid), 0);
        chk_levels("R1 reset");

        // queue 3 fills with no buffers: counts, stall, then saturation
        repeat (3) drive(4'b1000, 32'd0);
        chk_levels("R7 arrivals");
        chk("R2 no grant without buffers", int'(grant_valid), 0);
        repeat (257) drive(4'b1000, 32'd0);
        chk("R8 packet level saturates", int'(pkt_level[31:24]), 255);
        chk_levels("R8 R10 stalled top queue");

        // stalled queue 3 is bypassed by queue 0
        drive(4'b0000, {8'd0, 8'd0, 8'd0, 8'd2});
        drive(4'b0001, 32'd0);
        serve(0, 4'b0000, 32'd0);

        // load queues 1 and 2 without buffers, then a stray completion while idle
        drive(4'b0010, 32'd0);
        drive(4'b0010, 32'd0);
        drive(4'b0100, 32'd0);
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R6 stray done no grant", int'(grant_valid), 0);
        chk_levels("R6 stray done ignored");

        // buffers everywhere: queue 3 drains its ring, then 2, then 1
        drive(4'b0000, {8'd5, 8'd5, 8'd5, 8'd0});
        serve(3, 4'b1000, {8'd1, 8'd0, 8'd0, 8'd0});   // R9 arrival+return with done
        repeat (5) serve(3, 4'b0000, 32'd0);
        serve(2, 4'b0000, 32'd0);
        serve(1, 4'b0000, 32'd0);
        serve(1, 4'b0000, 32'd0);
        repeat (2) @(negedge clk);
        chk("R4 idle with queue 3 stalled", int'(grant_valid), 0);
        chk_levels("R4 final stall");

        // free level saturation, then a grant that retires from a full ring
        drive(4'b0000, {8'd0, 8'd0, 8'd0, 8'd200});
        drive(4'b0000, {8'd0, 8'd0, 8'd0, 8'd200});
        chk("R8 free level saturates", int'(free_level[7:0]), 255);
        drive(4'b0001, 32'd0);
        serve(0, 4'b0000, 32'd0);
        chk("R6 retire from full ring", int'(free_level[7:0]), 254);
        chk("R3 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end
endmodule